// File: doc/BRIEF.md
# Composite Sync Separator and Line Regenerator

This block accepts one composite synchronisation stream, picked by two select bits from three one-bit candidates: a dedicated sync pin, a sliced sync-on-green signal, or a data-enable stream recovered from a digital video link. It turns that stream into clean internal horizontal and vertical sync pulses for the downstream timing logic. A polarity bit normalises the source, so a sync pulse is always treated as active-low inside the block.

Vertical sync is found by measuring the low time of each pulse in clock cycles against a programmable broad-pulse threshold. The block learns the line period from the spacing of leading edges. Edges that arrive at about half a line, which are equalizing and serration pulses, are rejected. A line-period flywheel keeps horizontal sync running through the vertical interval and across missing pulses. The block also drives the enable of the external sync-on-green slicer, and can optionally hold that enable low while vertical sync is active.

Top module: `csync_regen`

## Requirements
- R1: The decoder input is `de_in` when `sel_dvi`=1, whatever `sel_sog` is. It is `sog_in` when `sel_dvi`=0 and `sel_sog`=1, and `sync_pin` when both select bits are 0. The unselected inputs have no effect on any output.
- R2: With `pol_inv`=0 a sync pulse is a low level on the source. With `pol_inv`=1 it is a high level. Both polarities give identical output timing.
- R3: A pulse whose active time in clock cycles is greater than `broad_thr` is broad. `vs_out` rises two clocks after the trailing edge of the second consecutive broad pulse. It falls two clocks after the trailing edge of the first non-broad pulse that follows.
- R4: `slicer_en` is 0 while `sog_vs_gate`=1 and `vs_out`=1. Otherwise it equals `sog_en`.
- R5: After reset, `locked` rises on the third leading edge, when two consecutive measured periods agree within period/8. While `locked`=0, `hs_out` and `vs_out` stay 0.
- R6: Each `hs_out` pulse lasts exactly `hs_width` clocks. A pulse produced by an accepted leading edge rises two clocks after that edge appears on the source.
- R7: While locked and outside vertical sync, a leading edge that arrives less than period minus period/8 clocks after the last hsync start produces no `hs_out` pulse.
- R8: While locked, when `vs_out`=1 or an expected edge is missing, `hs_out` pulses are generated exactly one learned period after the previous hsync start. Sync resumes on the next valid leading edge.
- R9: Any change of `sel_dvi`, `sel_sog` or `pol_inv` clears `locked` by the next clock and suppresses `hs_out` and `vs_out`.
- R10: A vertical interval with up to 40 equalizing pulses on each side still yields correct vsync timing and an unbroken hsync train at the line period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_dvi | input | 1 | Select the data-enable stream (top priority) |
| sel_sog | input | 1 | Select the sliced sync-on-green input |
| sync_pin | input | 1 | Composite sync from the dedicated pin |
| sog_in | input | 1 | Sliced sync-on-green |
| de_in | input | 1 | Data enable from the digital link |
| pol_inv | input | 1 | 1 = source pulses are active-high |
| broad_thr | input | CW | Broad-pulse threshold in clocks |
| hs_width | input | CW | Regenerated hsync width in clocks |
| sog_en | input | 1 | Slicer enable request |
| sog_vs_gate | input | 1 | Drop slicer enable during vsync |
| hs_out | output | 1 | Regenerated hsync, active-high |
| vs_out | output | 1 | Decoded vsync, active-high |
| slicer_en | output | 1 | Enable for the sync-on-green slicer |
| locked | output | 1 | Line period learned |

## Verification
The sweep tries every select combination, including both settings of `sel_sog` under `sel_dvi`, with both polarities. The unselected inputs toggle on their own pattern, so a wrong mux or polarity choice shifts or adds hsync pulses. Each run drives a full frame: normal lines, then half-line equalizing pulses, then broad serration pulses, then post-equalizing pulses, a line whose pulse is left out, and more lines. Comparing the hsync rise times against one arithmetic sequence separates accepted edges, rejected half-line edges and flywheel pulses. One run uses 40 equalizing pulses per side. After each frame the polarity is flipped to confirm that the lock is dropped.

// File: rtl/csync_regen.sv
module csync_regen #(
  parameter int CW     = 12,
  parameter int TOL_SH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_dvi,
  input  logic          sel_sog,
  input  logic          sync_pin,
  input  logic          sog_in,
  input  logic          de_in,
  input  logic          pol_inv,
  input  logic [CW-1:0] broad_thr,
  input  logic [CW-1:0] hs_width,
  input  logic          sog_en,
  input  logic          sog_vs_gate,
  output logic          hs_out,
  output logic          vs_out,
  output logic          slicer_en,
  output logic          locked
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          raw, s_d, s_q, fe, re, broad, vs, chg;
  logic [2:0]    cfg_q;
  logic [1:0]    bcnt;
  logic [CW-1:0] lcnt, ecnt, per, tol, diff, hcnt;
  logic          per_ok, match, edge_ok, fly, start;

  assign raw = sel_dvi ? de_in : (sel_sog ? sog_in : sync_pin);
  assign fe  = s_q & ~s_d;
  assign re  = ~s_q & s_d;
  assign broad = lcnt > broad_thr;
  assign chg = cfg_q != {sel_dvi, sel_sog, pol_inv};

  assign tol     = per >> TOL_SH;
  assign diff    = (ecnt > per) ? ecnt - per : per - ecnt;
  assign match   = per_ok && (diff <= tol);
  assign edge_ok = fe && !vs && (ecnt >= per - tol);
  assign fly     = ecnt >= per;
  assign start   = locked ? (edge_ok || fly) : fe;

  assign hs_out    = locked && (hcnt != '0);
  assign vs_out    = locked && vs;
  assign slicer_en = sog_en && !(sog_vs_gate && vs_out);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_d   <= 1'b1;
      s_q   <= 1'b1;
      lcnt  <= '0;
      bcnt  <= '0;
      vs    <= 1'b0;
      cfg_q <= '0;
    end else begin
      s_d   <= raw ^ pol_inv;
      s_q   <= s_d;
      cfg_q <= {sel_dvi, sel_sog, pol_inv};
      if (!s_d) lcnt <= (lcnt == CMAX) ? CMAX : lcnt + ONE;
      else      lcnt <= '0;
      if (re) begin
        if (broad) begin
          bcnt <= (bcnt == 2'd2) ? 2'd2 : bcnt + 2'd1;
          if (bcnt != 2'd0) vs <= 1'b1;
        end else begin
          bcnt <= '0;
          vs   <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || chg) begin
      ecnt   <= CMAX;
      per    <= '0;
      per_ok <= 1'b0;
      locked <= 1'b0;
      hcnt   <= '0;
    end else begin
      if (start)              ecnt <= ONE;
      else if (ecnt != CMAX)  ecnt <= ecnt + ONE;
      if (!locked && fe) begin
        if (match) locked <= 1'b1;
        else begin
          per    <= ecnt;
          per_ok <= 1'b1;
        end
      end
      if (start)             hcnt <= hs_width;
      else if (hcnt != '0)   hcnt <= hcnt - ONE;
    end
  end
endmodule

module csync_regen_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_dvi,
  input logic          sel_sog,
  input logic          pol_inv,
  input logic [CW-1:0] hs_width,
  input logic          sog_en,
  input logic          sog_vs_gate,
  input logic          hs_out,
  input logic          vs_out,
  input logic          slicer_en,
  input logic          locked
);
  logic [CW-1:0] hrun;
  logic [2:0]    cfg_prev;
  logic          pv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hrun     <= '0;
      cfg_prev <= '0;
      pv       <= 1'b0;
    end else begin
      hrun     <= hs_out ? ((hrun == '1) ? hrun : hrun + CW'(1)) : '0;
      cfg_prev <= {sel_dvi, sel_sog, pol_inv};
      pv       <= 1'b1;
    end
  end

  a_r4_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sog_vs_gate && vs_out) |-> !slicer_en);

  a_r4_on_outside_vs: assert property (@(posedge clk) disable iff (!rst_n)
    (sog_en && !vs_out) |-> slicer_en);

  a_r5_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!hs_out && !vs_out));

  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !hs_out && hrun != '0) |-> (hrun == hs_width));

  a_r9_change_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && ({sel_dvi, sel_sog, pol_inv} != cfg_prev)) |=> !locked);
endmodule

bind csync_regen csync_regen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_dvi(sel_dvi), .sel_sog(sel_sog),
  .pol_inv(pol_inv), .hs_width(hs_width), .sog_en(sog_en),
  .sog_vs_gate(sog_vs_gate), .hs_out(hs_out), .vs_out(vs_out),
  .slicer_en(slicer_en), .locked(locked)
);

// File: tb/csync_regen_tb.sv
module csync_regen_tb;
  localparam int CLK_NS = 10;
  localparam int CW     = 12;
  localparam int P      = 64;
  localparam int H      = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_dvi = 0, sel_sog = 0, pol_inv = 0, sog_en = 1, sog_vs_gate = 0;
  logic [CW-1:0] broad_thr = 12, hs_width = 4;
  logic phys = 1'b1, junk = 1'b0;
  logic sync_pin, sog_in, de_in;
  logic hs_out, vs_out, slicer_en, locked;

  int cyc = 0, checks = 0, errors = 0;
  int rise_t [0:1023];
  int n_rise = 0, wbad = 0, hlen = 0, vr_t = 0, vf_t = 0;
  logic hs_p = 0, vs_p = 0, act_prev = 0;
  int last_fe = 0, last_re = 0, jcnt = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sync_pin = (!sel_dvi && !sel_sog) ? phys : junk;
  assign sog_in   = (!sel_dvi && sel_sog)  ? phys : ~junk;
  assign de_in    = sel_dvi ? phys : junk;

  csync_regen #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_dvi(sel_dvi), .sel_sog(sel_sog),
    .sync_pin(sync_pin), .sog_in(sog_in), .de_in(de_in), .pol_inv(pol_inv),
    .broad_thr(broad_thr), .hs_width(hs_width), .sog_en(sog_en),
    .sog_vs_gate(sog_vs_gate), .hs_out(hs_out), .vs_out(vs_out),
    .slicer_en(slicer_en), .locked(locked)
  );

  always @(negedge clk) begin
    if (hs_out && !hs_p && n_rise < 1024) begin
      rise_t[n_rise] = cyc;
      n_rise = n_rise + 1;
    end
    if (hs_out) hlen = hlen + 1;
    else begin
      if (hs_p && hlen != int'(hs_width)) wbad = wbad + 1;
      hlen = 0;
    end
    if (vs_out && !vs_p) vr_t = cyc;
    if (!vs_out && vs_p) vf_t = cyc;
    hs_p = hs_out;
    vs_p = vs_out;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit act);
    @(negedge clk);
    if (act && !act_prev) last_fe = cyc;
    if (!act && act_prev) last_re = cyc;
    act_prev = act;
    phys = pol_inv ? act : !act;
    jcnt = jcnt + 1;
    if (jcnt % 7 == 0) junk = ~junk;
  endtask

  task automatic halfl(input int low);
    for (int i = 0; i < H; i++) step(i < low);
  endtask

  task automatic line(input bit present);
    halfl(present ? 6 : 0);
    halfl(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int run = 0; run < 8; run++) begin
      int e_cnt, base, w0, nl, t_first, mism, bad_a, bad_e;
      bit gate;
      e_cnt = (run == 7) ? 40 : 2 * (run % 3 + 1) + 2;
      gate  = run[0] ^ run[1];
      rst_n = 1'b0;
      sel_dvi = run[2]; sel_sog = run[1]; pol_inv = run[0];
      sog_vs_gate = gate; hs_width = CW'(3 + run);
      act_prev = 0; phys = pol_inv ? 1'b0 : 1'b1;
      repeat (3) @(negedge clk);
      chk(!hs_out && !vs_out && !locked, "R5 reset quiet", {hs_out, vs_out, locked}, 0);
      chk(slicer_en == 1'b1, "R4 reset slicer", slicer_en, 1);
      rst_n = 1'b1;
      repeat (4) step(0);
      base = n_rise; w0 = wbad;
      line(1); t_first = last_fe;
      line(1);
      chk(locked == 1'b0 && n_rise == base, "R5 no lock after one period", locked, 0);
      line(1); line(1);
      chk(locked == 1'b1, "R5 lock after two matching periods", locked, 1);
      for (int i = 0; i < e_cnt; i++) halfl(3);
      for (int i = 0; i < 6; i++) begin
        halfl(26);
        if (i == 1) bad_e = last_re + 2;
        if (i == 3) begin
          chk(vs_out == 1'b1, "R3 vsync active in broad pulses", vs_out, 1);
          chk(slicer_en == !gate, "R4 slicer during vsync", slicer_en, !gate);
        end
      end
      chk(vr_t == bad_e, "R3 vsync rise timing", vr_t, bad_e);
      halfl(3);
      bad_e = last_re + 2;
      for (int i = 1; i < e_cnt; i++) halfl(3);
      chk(vf_t == bad_e, "R3 vsync fall timing", vf_t, bad_e);
      chk(vs_out == 1'b0 && slicer_en == 1'b1, "R4 slicer after vsync", slicer_en, 1);
      line(1); line(1);
      line(0);
      line(1); line(1); line(1);
      nl = 13 + e_cnt;
      mism = 0; bad_a = 0; bad_e = 0;
      for (int k = 0; k < nl - 2; k++) begin
        int ex;
        ex = t_first + 2 + (k + 2) * P;
        if (rise_t[base + k] != ex && mism == 0) begin
          bad_a = rise_t[base + k]; bad_e = ex;
        end
        if (rise_t[base + k] != ex) mism = mism + 1;
      end
      chk(n_rise - base == nl - 2, "R7 R8 R10 hsync pulse count", n_rise - base, nl - 2);
      chk(mism == 0, "R1 R2 R6 R8 hsync rise times", bad_a, bad_e);
      chk(wbad == w0, "R6 hsync width", wbad - w0, 0);
      @(negedge clk);
      chk(locked == 1'b1, "R5 lock held through frame", locked, 1);
      pol_inv = ~pol_inv;
      @(negedge clk);
      chk(locked == 1'b0 && !hs_out && !vs_out, "R9 source change unlocks", locked, 0);
      repeat (4) @(negedge clk);
      chk(n_rise - base == nl - 2, "R9 no hsync after unlock", n_rise - base, nl - 2);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule